// File: doc/BRIEF.md
# Serial Radix (-1+j) Digit-Pair Adder

This block adds two complex numbers written in the positional system whose base is (-1+j). Every digit is 0 or 1 and digit k has weight (-1+j)^k, so a single bit string holds both the real and the imaginary part. The operands arrive least significant first, one pair of digits from each operand per clock. Each accepted pair produces a two-digit slice of the result and updates an eight-digit carry pattern held between cycles. An n-digit addition therefore takes n/2 steps.

In this base, adding 1 and 1 at one position leaves 0 there and sends ones to the positions two and three places higher. A carry is therefore a short digit pattern and not a single bit. Fifteen such patterns can occur. The step function is organised as nine evaluation banks. A symmetric decoder picks one bank from the unordered combination of the two operand pairs. Each bank takes the current carry pattern and returns the two result digits and the next pattern. The bank contents are derived by Gaussian-integer arithmetic, so no stored table is needed. On the final pair the caller raises a carry-release input, and the block presents the final carry pattern as the eight most significant result digits.

Top module: `cbn_serial_adder`

## Requirements
- R1: Digit k of an operand or of the result has weight (-1+j)^k. `a_pair`/`b_pair` bit 0 is the even position 2i and bit 1 is position 2i+1 of step i, least significant pair first. The result digits `sum_pair` of step i occupy the same positions, and `carry_out` bit m occupies position 2N+m after N steps. The assembled result equals the complex sum of the operands.
- R2: With a zero carry, the pairs a=11 and b=10 give result digits 01 and next carry 00000110 (a 1+1 at one position sends ones two and three positions up).
- R3: The result depends only on the unordered combination of the two operand pairs, so swapping the operands gives identical outputs at every step.
- R4: Each cycle with `in_valid` high is one step. Its `sum_pair` appears with `sum_valid` high one clock later. In other cycles `sum_valid` is low.
- R5: The carry held between steps, and any released carry, is one of the 15 patterns 00, 01, 02, 03, 04, 06, 07, 0E, 1C, 1D, 3A, 74, 75, E9, EB (hex).
- R6: Cycles with `in_valid` and `start` both low leave the held carry unchanged.
- R7: `carry_out` is zero except in the cycle after a step taken with `co_en` high. In that cycle it shows the step's next carry and `done` is high. After such a step the held carry is zero.
- R8: `start` clears the held carry. A pair accepted in the same cycle as `start` is added with a zero carry.
- R9: The operands 011111 (-2+j) and 111110 (1-3j) in three steps give result digits 01, 10, 10 and a released carry 00000011, which together equal -1-2j.
- R10: During and right after reset, `sum_valid`, `done`, `sum_pair` and `carry_out` are zero.
- R11: The pairs 00+00 with held carry 00000110 give result digits 10 and next carry 00000001.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear the carry; begins a new addition |
| in_valid | input | 1 | Operand pairs are valid this cycle |
| a_pair | input | 2 | Two digits of operand A |
| b_pair | input | 2 | Two digits of operand B |
| co_en | input | 1 | This is the final pair; release the carry |
| sum_valid | output | 1 | `sum_pair` holds a fresh result slice |
| sum_pair | output | 2 | Two result digits |
| done | output | 1 | The final slice and carry are on the outputs |
| carry_out | output | 8 | Final carry pattern, the top result digits |

## Verification
A wrong carry pattern stays hidden in the block until a later step. It shows up in the next `sum_pair` after the corrupted step, or in `carry_out` at the release, and then the assembled value no longer equals the complex sum. A decoder that maps one operand order to the wrong bank shows up in the first step of the swapped-operand run. A carry that is not cleared by `start` or by the release corrupts the low digits of the next addition, one cycle after its first pair.

// File: rtl/cbn_pkg.sv
package cbn_pkg;

    localparam int CARRY_W   = 8;
    localparam int NUM_BANKS = 9;
    localparam int PAIR_W    = 2;
    localparam int GW        = 10;
    localparam int SEL_W     = $clog2(NUM_BANKS);

    typedef logic signed [GW-1:0] gint_t;
    typedef struct packed {
        gint_t re;
        gint_t im;
    } gauss_t;

    function automatic gauss_t g_add(gauss_t x, gauss_t y);
        gauss_t r;
        gint_t  xr, xi, yr, yi;
        xr = x.re; xi = x.im; yr = y.re; yi = y.im;
        r.re = xr + yr;
        r.im = xi + yi;
        return r;
    endfunction

    // Multiply by the base (-1+j).
    function automatic gauss_t g_mul_base(gauss_t x);
        gauss_t r;
        gint_t  xr, xi;
        xr = x.re; xi = x.im;
        r.re = -xr - xi;
        r.im = xr - xi;
        return r;
    endfunction

    // Lowest digit of x in base (-1+j).
    function automatic logic g_low_digit(gauss_t x);
        return x.re[0] ^ x.im[0];
    endfunction

    // Remove the lowest digit and divide by the base.
    function automatic gauss_t g_strip_div(gauss_t x);
        gauss_t r;
        gint_t  xr, xi;
        xr = x.re; xi = x.im;
        if (xr[0] ^ xi[0]) xr = xr - gint_t'(1);
        r.re = (xi - xr) >>> 1;
        r.im = (-xr - xi) >>> 1;
        return r;
    endfunction

    function automatic gauss_t pattern_value(logic [CARRY_W-1:0] p);
        gauss_t acc, w;
        acc = '0;
        w.re = gint_t'(1);
        w.im = gint_t'(0);
        for (int k = 0; k < CARRY_W; k++) begin
            if (p[k]) acc = g_add(acc, w);
            w = g_mul_base(w);
        end
        return acc;
    endfunction

    // Value of the two operand pairs summed, per bank.
    function automatic gauss_t bank_value(int idx);
        gauss_t r;
        case (idx)
            1:       begin r.re = gint_t'(1);  r.im = gint_t'(0); end
            2:       begin r.re = gint_t'(-1); r.im = gint_t'(1); end
            3:       begin r.re = gint_t'(0);  r.im = gint_t'(1); end
            4:       begin r.re = gint_t'(2);  r.im = gint_t'(0); end
            5:       begin r.re = gint_t'(1);  r.im = gint_t'(1); end
            6:       begin r.re = gint_t'(-2); r.im = gint_t'(2); end
            7:       begin r.re = gint_t'(-1); r.im = gint_t'(2); end
            8:       begin r.re = gint_t'(0);  r.im = gint_t'(2); end
            default: begin r.re = gint_t'(0);  r.im = gint_t'(0); end
        endcase
        return r;
    endfunction

    function automatic logic carry_is_legal(logic [CARRY_W-1:0] p);
        case (p)
            8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h06, 8'h07, 8'h0E,
            8'h1C, 8'h1D, 8'h3A, 8'h74, 8'h75, 8'hE9, 8'hEB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cbn_pair_decode.sv
module cbn_pair_decode
    import cbn_pkg::*;
(
    input  logic [PAIR_W-1:0]    a_pair,
    input  logic [PAIR_W-1:0]    b_pair,
    output logic [NUM_BANKS-1:0] bank_sel
);

    logic [SEL_W-1:0] idx;

    // Operand order does not matter: both orders land in one bank.
    always_comb begin
        case ({a_pair, b_pair})
            4'b0000:                             idx = SEL_W'(0);
            4'b0001, 4'b0100:                    idx = SEL_W'(1);
            4'b0010, 4'b1000:                    idx = SEL_W'(2);
            4'b0011, 4'b1100, 4'b0110, 4'b1001:  idx = SEL_W'(3);
            4'b0101:                             idx = SEL_W'(4);
            4'b0111, 4'b1101:                    idx = SEL_W'(5);
            4'b1010:                             idx = SEL_W'(6);
            4'b1011, 4'b1110:                    idx = SEL_W'(7);
            default:                             idx = SEL_W'(8);
        endcase
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        assign bank_sel[g] = (idx == SEL_W'(g));
    end

endmodule

// File: rtl/cbn_bank_eval.sv
module cbn_bank_eval
    import cbn_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic [CARRY_W-1:0] carry_in,
    output logic [PAIR_W-1:0]  sum_pair,
    output logic [CARRY_W-1:0] carry_next,
    output logic               fits
);

    gauss_t t;

    always_comb begin
        t = g_add(pattern_value(carry_in), bank_value(BANK));
        for (int k = 0; k < PAIR_W; k++) begin
            sum_pair[k] = g_low_digit(t);
            t = g_strip_div(t);
        end
        for (int k = 0; k < CARRY_W; k++) begin
            carry_next[k] = g_low_digit(t);
            t = g_strip_div(t);
        end
        fits = (t == '0);
    end

endmodule

// File: rtl/cbn_serial_adder.sv
module cbn_serial_adder
    import cbn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               in_valid,
    input  logic [PAIR_W-1:0]  a_pair,
    input  logic [PAIR_W-1:0]  b_pair,
    input  logic               co_en,
    output logic               sum_valid,
    output logic [PAIR_W-1:0]  sum_pair,
    output logic               done,
    output logic [CARRY_W-1:0] carry_out
);

    typedef struct packed {
        logic [CARRY_W-1:0] carry;
        logic [PAIR_W-1:0]  sum;
        logic               sum_valid;
        logic               done;
        logic [CARRY_W-1:0] cout;
    } state_t;

    state_t st_d, st_q;

    logic [CARRY_W-1:0]   carry_src;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [PAIR_W-1:0]    bank_sum   [NUM_BANKS];
    logic [CARRY_W-1:0]   bank_carry [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_fit;
    logic [PAIR_W-1:0]    sel_sum;
    logic [CARRY_W-1:0]   sel_carry;
    logic                 sel_fit;

    assign carry_src = start ? '0 : st_q.carry;

    cbn_pair_decode u_decode (
        .a_pair   (a_pair),
        .b_pair   (b_pair),
        .bank_sel (bank_sel)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        cbn_bank_eval #(.BANK(g)) u_bank (
            .carry_in   (carry_src),
            .sum_pair   (bank_sum[g]),
            .carry_next (bank_carry[g]),
            .fits       (bank_fit[g])
        );
    end

    always_comb begin
        sel_sum   = '0;
        sel_carry = '0;
        sel_fit   = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_sel[i]) begin
                sel_sum   = sel_sum | bank_sum[i];
                sel_carry = sel_carry | bank_carry[i];
                sel_fit   = sel_fit | bank_fit[i];
            end
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.sum_valid = 1'b0;
        st_d.done      = 1'b0;
        st_d.sum       = '0;
        st_d.cout      = '0;
        if (start) st_d.carry = '0;
        if (in_valid) begin
            st_d.sum_valid = 1'b1;
            st_d.sum       = sel_sum;
            st_d.carry     = co_en ? '0 : sel_carry;
            if (co_en) begin
                st_d.done = 1'b1;
                st_d.cout = sel_carry;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_valid = st_q.sum_valid;
    assign sum_pair  = st_q.sum;
    assign done      = st_q.done;
    assign carry_out = st_q.cout;

    // R3: exactly one bank is chosen for any operand pair
    a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $countones(bank_sel) == 1);

    // R4: an accepted pair yields a slice next cycle
    a_r4_valid_to_sum: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> sum_valid);

    a_r4_idle_no_sum: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !sum_valid);

    // R5: held carry stays within the reachable set
    a_r5_carry_legal: assert property (@(posedge clk) disable iff (!rst_n)
        carry_is_legal(st_q.carry));

    a_r5_step_fits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> sel_fit);

    // R6: idle cycles keep the carry
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> $stable(st_q.carry));

    // R7: carry lines quiet unless released
    a_r7_cout_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> carry_out == '0);

    a_r7_release_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && co_en) |=> (done && st_q.carry == '0));

    // R8: start alone clears the carry
    a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> st_q.carry == '0);

endmodule

// File: tb/cbn_serial_adder_tb_top.sv
module cbn_serial_adder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] a_pair = '0;
    logic [1:0] b_pair = '0;
    logic       co_en = 1'b0;
    logic       sum_valid;
    logic [1:0] sum_pair;
    logic       done;
    logic [7:0] carry_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cbn_serial_adder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .a_pair(a_pair), .b_pair(b_pair), .co_en(co_en),
        .sum_valid(sum_valid), .sum_pair(sum_pair), .done(done),
        .carry_out(carry_out)
    );

    // Operand table: a_re, a_im, b_re, b_im
    localparam int NVEC = 9;
    localparam int VEC [NVEC][4] = '{
        '{-2,  1,  1, -3}, '{ 0,  0,  0,  0}, '{ 1,  0,  1,  0},
        '{-1,  0,  1,  0}, '{ 3, -2, -4,  5}, '{-5, -5, -5, -5},
        '{ 5,  4, -3,  2}, '{ 2,  5,  5, -1}, '{-4,  3,  4, -3}
    };

    localparam logic [7:0] LEGAL [15] = '{
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h06, 8'h07, 8'h0E,
        8'h1C, 8'h1D, 8'h3A, 8'h74, 8'h75, 8'hE9, 8'hEB
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] to_cbn(input int re_i, input int im_i);
        logic [15:0] d;
        int re, im, nr;
        re = re_i; im = im_i;
        for (int k = 0; k < 16; k++) begin
            d[k] = ((re + im) % 2) != 0;
            if (d[k]) re = re - 1;
            nr = (im - re) / 2;
            im = (-re - im) / 2;
            re = nr;
        end
        return d;
    endfunction

    function automatic void cbn_value(input logic [23:0] d, output int re, output int im);
        int wr, wi, t;
        re = 0; im = 0; wr = 1; wi = 0;
        for (int k = 0; k < 24; k++) begin
            if (d[k]) begin re += wr; im += wi; end
            t  = -wr - wi;
            wi = wr - wi;
            wr = t;
        end
    endfunction

    function automatic int is_legal(input logic [7:0] p);
        for (int i = 0; i < 15; i++) if (LEGAL[i] == p) return 1;
        return 0;
    endfunction

    // Drive at the falling edge, step through one rising edge, sample at the next fall.
    task automatic step(input logic [1:0] a, input logic [1:0] b,
                        input logic st, input logic co, input logic v);
        a_pair = a; b_pair = b; start = st; co_en = co; in_valid = v;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; start = 1'b0; co_en = 1'b0;
    endtask

    task automatic run_op(input logic [15:0] ad, input logic [15:0] bd,
                          output logic [23:0] res, output int proto_ok);
        proto_ok = 1;
        res = '0;
        for (int i = 0; i < 8; i++) begin
            step(ad[2*i +: 2], bd[2*i +: 2], i == 0, i == 7, 1'b1);
            res[2*i +: 2] = sum_pair;
            if (!sum_valid) proto_ok = 0;
            if (i == 7) begin
                res[23:16] = carry_out;
                if (!done) proto_ok = 0;
            end else if (done || carry_out != 0) begin
                proto_ok = 0;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] r1, r2;
        logic [15:0] ad, bd;
        int ok1, ok2, vre, vim;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 sum_valid in reset", int'(sum_valid), 0);
        chk("R10 carry_out in reset", int'(carry_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done after reset", int'(done), 0);
        chk("R10 sum_pair after reset", int'(sum_pair), 0);

        // R1 R3 R5: table of operands, each run in both operand orders
        for (int v = 0; v < NVEC; v++) begin
            ad = to_cbn(VEC[v][0], VEC[v][1]);
            bd = to_cbn(VEC[v][2], VEC[v][3]);
            run_op(ad, bd, r1, ok1);
            step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
            run_op(bd, ad, r2, ok2);
            cbn_value(r1, vre, vim);
            chk("R1 real part", vre, VEC[v][0] + VEC[v][2]);
            chk("R1 imag part", vim, VEC[v][1] + VEC[v][3]);
            chk("R4 R7 handshake", ok1 & ok2, 1);
            chk("R3 swapped operands", int'(r2), int'(r1));
            chk("R5 released carry legal", is_legal(r1[23:16]), 1);
        end

        // R9: worked vector with idle gaps (R6)
        step(2'b11, 2'b10, 1'b1, 1'b0, 1'b1);
        chk("R9 slice 0", int'(sum_pair), 1);
        chk("R7 carry quiet before release", int'(carry_out), 0);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R4 idle no slice", int'(sum_valid), 0);
        step(2'b11, 2'b11, 1'b0, 1'b0, 1'b1);
        chk("R9 R6 slice 1", int'(sum_pair), 2);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b01, 2'b11, 1'b0, 1'b1, 1'b1);
        chk("R9 slice 2", int'(sum_pair), 2);
        chk("R9 final carry", int'(carry_out), 3);
        chk("R7 done on release", int'(done), 1);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        chk("R7 carry quiet after release", int'(carry_out), 0);

        // R2: 1+1 carry pattern, released at once
        step(2'b11, 2'b10, 1'b1, 1'b1, 1'b1);
        chk("R2 digits", int'(sum_pair), 1);
        chk("R2 carry pattern", int'(carry_out), 8'h06);

        // R7: carry cleared after release, no start needed
        step(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R7 carry cleared slice", int'(sum_pair), 0);
        chk("R7 carry cleared pattern", int'(carry_out), 0);

        // R11: 00+00 with held carry 00000110
        step(2'b11, 2'b10, 1'b1, 1'b0, 1'b1);
        step(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R11 digits", int'(sum_pair), 2);
        chk("R11 next carry", int'(carry_out), 1);

        // R8: start with a pair uses a zero carry
        step(2'b11, 2'b10, 1'b1, 1'b0, 1'b1);
        step(2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R8 same-cycle start digits", int'(sum_pair), 0);
        chk("R8 same-cycle start carry", int'(carry_out), 0);

        // R8: start alone clears the carry
        step(2'b11, 2'b10, 1'b1, 1'b0, 1'b1);
        step(2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R8 lone start digits", int'(sum_pair), 0);
        chk("R8 lone start carry", int'(carry_out), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule